// File: doc/BRIEF.md
# H-Bridge PWM Voltage Regulator

This block is the digital controller for a single H-bridge. A two-bit direction command picks one of four bridge states: coast, forward, reverse or brake. The block turns that state into registered enables for the two high-side and two low-side switches. In forward and reverse it runs a fixed-period PWM. During the on time the diagonal pair for the chosen direction conducts. During the off time both high-side switches are closed, so the winding current circulates through the top of the bridge.

The duty cycle is trimmed once per PWM period by an up/down servo. One quarter of the digitised average bridge voltage is compared with a setpoint built from a 6-bit code. The duty rises when the measurement is low, falls when it is high, and holds when the two are equal. The servo is overridden in four cases:
- Entering drive from coast or brake restarts the duty at zero (soft start).
- A setpoint above the supply estimate drives the duty to full.
- Reserved setpoint codes give zero duty.
- A current-limit request pulls the duty down.

A halt input from a fault block switches every gate off on the next clock and clears the duty.

Top module: `hbridge_pwm_reg`

## Requirements
- R1: `dirCmd[0]` is the first direction bit and `dirCmd[1]` the second. The four codes select:
  - 2'b01 (forward): during the on phase, `gateHiA` and `gateLoB` conduct.
  - 2'b10 (reverse): during the on phase, `gateHiB` and `gateLoA` conduct.
  - 2'b11 (brake): `gateHiA` and `gateHiB` are on and both low sides are off.
  - Every gate output is registered and takes effect one clock after its inputs.
- R2: With `dirCmd` = 2'b00 (coast), all four gates are off and `standby` is 1 one clock later. `standby` is 0 in every other state. During reset, all gates are off and `standby` is 1.
- R3: During the PWM off phase in forward or reverse, both high-side enables are on and both low-side enables are off.
- R4: The PWM period is `PERIOD_CYC` clocks. In each period the on phase lasts exactly as many clocks as the current duty value, which ranges from 0 to `PERIOD_CYC`.
- R5: Entering forward or reverse from coast or brake starts the duty at 0. The duty changes by at most `DUTY_STEP` per period, so the first period after entry has at most `DUTY_STEP` on clocks.
- R6: At each period end, the servo compares `avgVolt`/4 (integer) with `(vsetCode+1)*DAC_LSB`:
  - below the setpoint, the duty rises by `DUTY_STEP`, saturating at `PERIOD_CYC`;
  - above the setpoint, the duty falls by `DUTY_STEP`, saturating at 0;
  - equal to the setpoint, the duty is unchanged.
- R7: When `supplyVolt` is less than `4*(vsetCode+1)*DAC_LSB`, the duty ramps to `PERIOD_CYC` and stays there whatever `avgVolt` reads.
- R8: `vsetCode` values 0 to 5 are reserved and force the duty to 0. Code 6 is the lowest code that regulates.
- R9: While `curLimit` is 1, the duty falls by `DUTY_STEP` each period. This takes priority over both the servo and the supply bypass.
- R10: `haltReq` = 1 turns all four gates off one clock later and clears the duty. After release, the duty soft-starts again from 0.
- R11: A high-side and a low-side enable on the same bridge leg are never on together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| dirCmd | input | 2 | Direction bits (bit0 first bit, bit1 second bit) |
| vsetCode | input | 6 | Voltage setpoint code |
| avgVolt | input | VW | Digitised average differential bridge voltage |
| supplyVolt | input | VW | Digitised supply estimate, same units as avgVolt |
| curLimit | input | 1 | Current-limit request, forces duty down |
| haltReq | input | 1 | Fault-block disable, turns gates off and clears duty |
| gateHiA | output | 1 | High-side enable, leg A |
| gateLoA | output | 1 | Low-side enable, leg A |
| gateHiB | output | 1 | High-side enable, leg B |
| gateLoB | output | 1 | Low-side enable, leg B |
| standby | output | 1 | Coast / low-power flag |

## Verification
Some properties are checked on every cycle:
- no leg ever has both switches on;
- halt and coast darken the bridge one clock later;
- the duty never exceeds the period and never climbs faster than one step per period;
- reserved codes and current limit never produce an upward step.

Other behaviours only show over whole PWM periods, so the bench's scenarios are needed for them. These are the servo settling at full or zero duty, holding an intermediate duty, the supply bypass overriding a high measurement, and soft start after brake or halt. The bench measures on-clock counts over windows of one period.

// File: rtl/hbr_pkg.sv
package hbr_pkg;
  // Bridge state selected by the direction bits {second, first}
  typedef enum logic [1:0] {
    MODE_COAST = 2'b00,
    MODE_FWD   = 2'b01,
    MODE_REV   = 2'b10,
    MODE_BRAKE = 2'b11
  } bridgeMode_e;

  // Strobes from control to the duty datapath
  typedef struct packed {
    logic clr;
    logic inc;
    logic dec;
  } dutyCmd_t;

  // Comparison results from the datapath
  typedef struct packed {
    logic reserved;
    logic below;
    logic above;
    logic overSupply;
  } loopFlags_t;

  localparam int unsigned MIN_CODE = 6;
endpackage

// File: rtl/hbr_duty.sv
module hbr_duty
  import hbr_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 4494,
  parameter int unsigned DUTY_STEP  = 9,
  parameter int unsigned VW         = 12,
  parameter int unsigned DAC_LSB    = 4,
  localparam int unsigned DW = $clog2(PERIOD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dutyCmd_t      cmd,
  input  logic [5:0]    vsetCode,
  input  logic [VW-1:0] avgVolt,
  input  logic [VW-1:0] supplyVolt,
  output loopFlags_t    flags,
  output logic [DW-1:0] duty
);
  localparam logic [DW-1:0] FULL = DW'(PERIOD_CYC);
  localparam logic [DW-1:0] STEP = DW'(DUTY_STEP);

  logic [31:0] setTarget;
  logic [31:0] measQ;

  always_comb begin
    setTarget        = (32'(vsetCode) + 32'd1) * DAC_LSB;
    measQ            = 32'(avgVolt) >> 2;
    flags.reserved   = 32'(vsetCode) < MIN_CODE;
    flags.below      = measQ < setTarget;
    flags.above      = measQ > setTarget;
    flags.overSupply = 32'(supplyVolt) < (setTarget << 2);
  end

  always_ff @(posedge clk) begin
    if (!rstN)          duty <= '0;
    else if (cmd.clr)   duty <= '0;
    else if (cmd.inc)   duty <= (duty >= FULL - STEP) ? FULL : duty + STEP;
    else if (cmd.dec)   duty <= (duty <= STEP) ? '0 : duty - STEP;
  end

  // R4
  duty_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(duty) <= PERIOD_CYC);
  // R5
  step_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> 32'(duty) <= 32'($past(duty)) + DUTY_STEP);
  // R8
  reserved_nostep_chk: assert property (@(posedge clk) disable iff (!rstN)
    flags.reserved |-> !(cmd.inc || cmd.dec));
endmodule

// File: rtl/hbr_ctrl.sv
module hbr_ctrl
  import hbr_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 4494,
  localparam int unsigned DW = $clog2(PERIOD_CYC + 1),
  localparam int unsigned CW = $clog2(PERIOD_CYC)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    dirCmd,
  input  logic          curLimit,
  input  logic          haltReq,
  input  loopFlags_t    flags,
  input  logic [DW-1:0] duty,
  output dutyCmd_t      cmd,
  output logic          gateHiA,
  output logic          gateLoA,
  output logic          gateHiB,
  output logic          gateLoB,
  output logic          standby
);
  bridgeMode_e   mode;
  logic          drive;
  logic          periodEnd;
  logic          pwmOn;
  logic [CW-1:0] cnt;

  assign mode      = bridgeMode_e'(dirCmd);
  assign drive     = (mode == MODE_FWD) || (mode == MODE_REV);
  assign periodEnd = (cnt == CW'(PERIOD_CYC - 1));
  assign pwmOn     = 32'(cnt) < 32'(duty);

  always_ff @(posedge clk) begin
    if (!rstN || periodEnd) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // Priority: halt/non-drive, reserved, current limit, bypass, servo
  always_comb begin
    cmd = '0;
    if (haltReq || !drive)      cmd.clr = 1'b1;
    else if (periodEnd) begin
      if (flags.reserved)       cmd.clr = 1'b1;
      else if (curLimit)        cmd.dec = 1'b1;
      else if (flags.overSupply) cmd.inc = 1'b1;
      else if (flags.below)     cmd.inc = 1'b1;
      else if (flags.above)     cmd.dec = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      {gateHiA, gateLoA, gateHiB, gateLoB} <= '0;
      standby <= 1'b1;
    end else begin
      standby <= (mode == MODE_COAST);
      if (haltReq) {gateHiA, gateLoA, gateHiB, gateLoB} <= '0;
      else begin
        unique case (mode)
          MODE_COAST: {gateHiA, gateLoA, gateHiB, gateLoB} <= 4'b0000;
          MODE_BRAKE: {gateHiA, gateLoA, gateHiB, gateLoB} <= 4'b1010;
          MODE_FWD:   {gateHiA, gateLoA, gateHiB, gateLoB} <= pwmOn ? 4'b1001 : 4'b1010;
          MODE_REV:   {gateHiA, gateLoA, gateHiB, gateLoB} <= pwmOn ? 4'b0110 : 4'b1010;
          default:    {gateHiA, gateLoA, gateHiB, gateLoB} <= 4'b0000;
        endcase
      end
    end
  end

  // R11
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(gateHiA && gateLoA) && !(gateHiB && gateLoB));
  // R10
  halt_dark_chk: assert property (@(posedge clk) disable iff (!rstN)
    haltReq |=> !(gateHiA || gateLoA || gateHiB || gateLoB));
  // R2
  coast_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirCmd == 2'b00) |=> standby && !(gateHiA || gateLoA || gateHiB || gateLoB));
  // R1
  brake_pair_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dirCmd == 2'b11 && !haltReq) |=> gateHiA && gateHiB && !gateLoA && !gateLoB);
  // R3
  recirc_chk: assert property (@(posedge clk) disable iff (!rstN)
    (drive && !haltReq && !pwmOn) |=> gateHiA && gateHiB);
  // R9
  curlim_down_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodEnd && curLimit && drive && !haltReq) |=> duty <= $past(duty));
endmodule

// File: rtl/hbridge_pwm_reg.sv
module hbridge_pwm_reg
  import hbr_pkg::*;
#(
  parameter int unsigned PERIOD_CYC = 4494,
  parameter int unsigned DUTY_STEP  = 9,
  parameter int unsigned VW         = 12,
  parameter int unsigned DAC_LSB    = 4,
  localparam int unsigned DW = $clog2(PERIOD_CYC + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [1:0]    dirCmd,
  input  logic [5:0]    vsetCode,
  input  logic [VW-1:0] avgVolt,
  input  logic [VW-1:0] supplyVolt,
  input  logic          curLimit,
  input  logic          haltReq,
  output logic          gateHiA,
  output logic          gateLoA,
  output logic          gateHiB,
  output logic          gateLoB,
  output logic          standby
);
  dutyCmd_t      cmd;
  loopFlags_t    flags;
  logic [DW-1:0] duty;

  hbr_ctrl #(.PERIOD_CYC(PERIOD_CYC)) ctrl_i (
    .clk, .rstN, .dirCmd, .curLimit, .haltReq, .flags, .duty, .cmd,
    .gateHiA, .gateLoA, .gateHiB, .gateLoB, .standby
  );

  hbr_duty #(
    .PERIOD_CYC(PERIOD_CYC), .DUTY_STEP(DUTY_STEP), .VW(VW), .DAC_LSB(DAC_LSB)
  ) duty_i (
    .clk, .rstN, .cmd, .vsetCode, .avgVolt, .supplyVolt, .flags, .duty
  );
endmodule

// File: tb/hbridge_pwm_reg_tb_top.sv
module hbridge_pwm_reg_tb_top;
  localparam int unsigned PER  = 16;
  localparam int unsigned STEP = 4;
  localparam int unsigned VW   = 12;
  localparam int unsigned LSB  = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] dirCmd = 2'b00;
  logic [5:0] vsetCode = 6'h10;
  logic [VW-1:0] avgVolt = '0;
  logic [VW-1:0] supplyVolt = 12'd1000;
  logic curLimit = 1'b0;
  logic haltReq = 1'b0;
  logic gateHiA, gateLoA, gateHiB, gateLoB, standby;

  int total = 0;
  int bad = 0;
  int shootCnt = 0;
  bit finished = 1'b0;

  typedef struct {
    string tag;
    int    sel;   // 0 hiA, 1 loA, 2 hiB, 3 loB, 4 standby
    int    le;    // 0 equal, 1 at most
    int    expv;
  } item_t;
  item_t q[$];

  always #2.5 clk = ~clk;

  hbridge_pwm_reg #(.PERIOD_CYC(PER), .DUTY_STEP(STEP), .VW(VW), .DAC_LSB(LSB)) dut_i (
    .clk, .rstN, .dirCmd, .vsetCode, .avgVolt, .supplyVolt, .curLimit, .haltReq,
    .gateHiA, .gateLoA, .gateHiB, .gateLoB, .standby
  );

  function automatic logic pick(int sel);
    case (sel)
      0: return gateHiA;
      1: return gateLoA;
      2: return gateHiB;
      3: return gateLoB;
      default: return standby;
    endcase
  endfunction

  task automatic chk(string tag, int act, int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // driver side: queue an expected window count and wait for the monitor
  task automatic expectWin(string tag, int sel, int le, int expv);
    item_t it;
    it.tag = tag; it.sel = sel; it.le = le; it.expv = expv;
    q.push_back(it);
    wait (q.size() == 0);
  endtask

  task automatic settle(int periods);
    repeat (periods * PER) @(negedge clk);
  endtask

  // monitor: counts on-samples of one gate over one PWM period
  initial begin
    forever begin
      item_t it;
      int cnt;
      wait (q.size() > 0);
      it = q[0];
      cnt = 0;
      for (int i = 0; i < PER; i++) begin
        @(negedge clk);
        if (pick(it.sel)) cnt++;
      end
      total++;
      if ((it.le == 0 && cnt != it.expv) || (it.le == 1 && cnt > it.expv)) begin
        bad++;
        $display("FAIL %s: actual=%0d expected=%s%0d", it.tag, cnt,
                 it.le ? "<=" : "", it.expv);
      end
      void'(q.pop_front());
    end
  end

  always @(negedge clk)
    if (rstN && ((gateHiA && gateLoA) || (gateHiB && gateLoB))) shootCnt++;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R2 reset state
    chk("R2 reset gates", int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);
    chk("R2 reset standby", int'(standby), 1);
    rstN = 1'b1;
    settle(1);

    // R5 soft start from coast
    dirCmd = 2'b01; avgVolt = 12'd0;
    expectWin("R5 first period from coast", 3, 1, STEP);
    settle(6);
    expectWin("R6 ramp up full", 3, 0, PER);
    expectWin("R1 forward hiA", 0, 0, PER);
    expectWin("R1 forward loA off", 1, 0, 0);
    expectWin("R3 full duty no recirc", 2, 0, 0);
    chk("R2 standby low in drive", int'(standby), 0);

    // R6 hold and down
    avgVolt = 12'd272; settle(3);
    expectWin("R6 hold at full", 3, 0, PER);
    avgVolt = 12'd1000; settle(7);
    expectWin("R6 ramp down zero", 3, 0, 0);
    expectWin("R3 recirc hiB", 2, 0, PER);
    expectWin("R3 recirc hiA", 0, 0, PER);
    avgVolt = 12'd272; settle(3);
    expectWin("R6 hold at zero", 3, 0, 0);

    // R4 intermediate duty: exactly two increments
    avgVolt = 12'd0; settle(2);
    avgVolt = 12'd272; settle(1);
    expectWin("R4 on time equals duty", 3, 0, 2 * STEP);
    expectWin("R3 off time recirc", 2, 0, PER - 2 * STEP);

    // R9 current limit
    avgVolt = 12'd0; settle(6);
    curLimit = 1'b1; settle(6);
    expectWin("R9 curlimit overrides servo", 3, 0, 0);
    supplyVolt = 12'd100; settle(3);
    expectWin("R9 curlimit overrides bypass", 3, 0, 0);
    curLimit = 1'b0; avgVolt = 12'd1000; settle(6);
    expectWin("R7 bypass full despite high reading", 3, 0, PER);
    supplyVolt = 12'd1000; avgVolt = 12'd0; settle(2);

    // R1 reverse
    dirCmd = 2'b10; settle(6);
    expectWin("R1 reverse loA", 1, 0, PER);
    expectWin("R1 reverse hiB", 2, 0, PER);
    expectWin("R1 reverse hiA off", 0, 0, 0);
    expectWin("R1 reverse loB off", 3, 0, 0);

    // R1 brake, then R5 restart
    dirCmd = 2'b11; settle(1);
    expectWin("R1 brake hiA", 0, 0, PER);
    expectWin("R1 brake hiB", 2, 0, PER);
    expectWin("R1 brake loB off", 3, 0, 0);
    expectWin("R2 standby low in brake", 4, 0, 0);
    dirCmd = 2'b01;
    expectWin("R5 first period from brake", 3, 1, STEP);
    settle(6);

    // R8 reserved codes
    vsetCode = 6'd5; settle(2);
    expectWin("R8 code 5 zero duty", 3, 0, 0);
    vsetCode = 6'd6; settle(6);
    expectWin("R8 code 6 regulates", 3, 0, PER);
    vsetCode = 6'd0; settle(2);
    expectWin("R8 code 0 zero duty", 3, 0, 0);
    vsetCode = 6'h10; settle(6);

    // R10 halt
    haltReq = 1'b1;
    @(negedge clk);
    chk("R10 halt gates off", int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);
    repeat (3) @(negedge clk);
    haltReq = 1'b0;
    expectWin("R10 soft start after halt", 3, 1, STEP);
    settle(6);
    expectWin("R10 recovers full", 3, 0, PER);

    // R2 back to coast
    dirCmd = 2'b00;
    @(negedge clk);
    chk("R2 coast gates off", int'({gateHiA, gateLoA, gateHiB, gateLoB}), 0);
    chk("R2 coast standby", int'(standby), 1);

    // R11 no overlapping leg enables seen at any sample
    chk("R11 shoot-through samples", shootCnt, 0);

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule